// File: doc/BRIEF.md
# Pulse-Width Bit Decoder with Baud Learning

This block recovers clock and data on the receiving side of a single-wire serial line. On that line every bit period opens with a falling edge, and the length of the low phase that follows carries the bit value. A short low phase is a logical one and a long low phase is a logical zero. The decoder does not know the line rate in advance. After power-up, and whenever it decides its timing has gone bad, it watches a fixed number of bus periods. During that window it learns the shortest low phase, which it takes as the width of a one, and it learns the length of a bit period. It then decodes each bit, sends a recovered clock to the local controller, and raises a ready flag.

The learned timing is kept while the node sleeps. When the node's controller signals a new entry into Normal operation and the timing is still held, decoding starts on the very next falling edge. A power-on flag throws the timing away. There is also a self-healing path. A noise-shortened pulse inside the learning window gives a learned one-width that is too small, and every later bit then reads as zero. For that reason a run of consecutive zeros makes the block discard its timing and learn again without outside help.

Top module: `pwm_bit_decoder`

## Requirements
- R1: While reset or `por_i` is asserted, and from then until a `normal_start_i` pulse, `ready_o` is 0, `rclk_o` is 1 and `bit_valid_o` stays 0, even if the bus toggles. `por_i` also discards any learned timing.
- R2: A `normal_start_i` pulse with no learned timing opens a learning window of LEARN_PERIODS (default 33) bus periods. During that window no `bit_valid_o` pulse occurs and `ready_o` stays 0.
- R3: The learned one-width is the shortest low phase seen in the window. A single short noise pulse therefore makes normal one-pulses decode as zeros.
- R4: A bit decodes as 0 when twice its low width exceeds three times the learned one-width, and as 1 otherwise. Widths are counted in system clocks. `data_o` carries the value while `bit_valid_o` pulses.
- R5: The first falling edge after the LEARN_PERIODS counted periods starts the first decoded bit.
- R6: `rclk_o` goes low at each accepted falling edge and returns high once the learned one-width has elapsed.
- R7: `ready_o` drops on `normal_start_i` and on entry to learning. It rises one cycle after the first `bit_valid_o`.
- R8: A `normal_start_i` pulse while timing is held skips learning. The next falling edge is decoded at once.
- R9: After ZERO_RUN (default 10) consecutive zeros, the last of them is still reported. The block then drops `ready_o` and re-learns for a full window.
- R10: A falling edge that comes less than half a learned bit period after the start of the current bit is ignored.
- R11: `bit_valid_o` is a single-cycle pulse, with exactly one pulse per accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| bus_i | input | 1 | Asynchronous bus level, idle high |
| normal_start_i | input | 1 | One-cycle strobe: entering Normal operation |
| por_i | input | 1 | Power-loss flag; discards learned timing |
| rclk_o | output | 1 | Recovered clock, idle high |
| data_o | output | 1 | Last decoded bit value |
| bit_valid_o | output | 1 | One-cycle pulse per decoded bit |
| ready_o | output | 1 | Decoding active and at least one bit delivered |

## Verification
Several properties are checked on every cycle: that no bit is produced while learning, that each bit pulse lasts a single cycle, that ready is never high without held timing, and how ready and the recovered clock follow a strobe, a power loss or a decoded one. Other behaviours depend on the bus waveform and can only be shown by the bench's scenarios. These are the minimum-width learning and its failure under a noise pulse, the exact window length before the first bit, the run of zeros that triggers re-learning, timing reuse after a sleep, the glitch guard, and the shape of the recovered clock.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;

    localparam int LEARN_PERIODS_DEF = 33;
    localparam int ZERO_RUN_DEF      = 10;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_LEARN,
        MODE_RUN
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        logic valid;
        logic data;
    } bit_ev_t;

    // Zero when 2*low > 3*one_width
    function automatic logic low_is_zero(input logic [31:0] low_w, input logic [31:0] one_w);
        logic [33:0] lhs;
        logic [33:0] rhs;
        lhs = {1'b0, low_w, 1'b0};
        rhs = {2'b00, one_w} + {1'b0, one_w, 1'b0};
        return lhs > rhs;
    endfunction

endpackage

// File: rtl/pwmdec_edge_sync.sv
module pwmdec_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sr;
    logic         prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '1;
            prev <= 1'b1;
        end else begin
            sr   <= {sr[MSB-1:0], async_i};
            prev <= sr[MSB];
        end
    end

    assign fall_o = prev & ~sr[MSB];
    assign rise_o = ~prev & sr[MSB];
endmodule

// File: rtl/pwmdec_learner.sv
module pwmdec_learner #(
    parameter int CW            = 17,
    parameter int LEARN_PERIODS = 33
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          enable_i,
    input  logic          fall_i,
    input  logic          rise_i,
    output logic          done_o,
    output logic          valid_o,
    output logic [CW-1:0] one_w_o,
    output logic [CW-1:0] period_o
);
    localparam int EW = $clog2(LEARN_PERIODS + 1);
    localparam logic [EW-1:0] LAST = EW'(LEARN_PERIODS);

    logic [CW-1:0] cnt, min_w, per_w, one_r, period_r;
    logic [EW-1:0] nfall;
    logic          in_low, seen, valid_r;

    assign done_o   = enable_i & fall_i & (nfall == LAST);
    assign valid_o  = valid_r;
    assign one_w_o  = one_r;
    assign period_o = period_r;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt      <= '0;
            min_w    <= '1;
            per_w    <= '0;
            one_r    <= '0;
            period_r <= '0;
            nfall    <= '0;
            in_low   <= 1'b0;
            seen     <= 1'b0;
            valid_r  <= 1'b0;
        end else if (enable_i) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (fall_i) begin
                cnt    <= '0;
                in_low <= 1'b1;
                seen   <= 1'b1;
                if (seen) per_w <= cnt;
                if (nfall != LAST) nfall <= nfall + 1'b1;
                if (done_o) begin
                    one_r    <= min_w;
                    period_r <= seen ? cnt : per_w;
                    valid_r  <= 1'b1;
                end
            end else if (rise_i && in_low) begin
                in_low <= 1'b0;
                if (cnt < min_w) min_w <= cnt;
            end
        end
    end
endmodule

// File: rtl/pwmdec_slicer.sv
module pwmdec_slicer
    import pwmdec_pkg::*;
#(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable_i,
    input  logic          arm_i,
    input  logic          fall_i,
    input  logic          rise_i,
    input  logic [CW-1:0] one_w_i,
    input  logic [CW-1:0] period_i,
    output logic          rclk_o,
    output bit_ev_t       ev_o
);
    logic [CW-1:0] cnt;
    phase_e        phase;
    logic          decided, first, rclk_r;
    bit_ev_t       ev_r;
    logic          guard_ok, over;

    assign guard_ok = first | (cnt >= (period_i >> 1));
    assign over     = low_is_zero(32'(cnt), 32'(one_w_i));
    assign rclk_o   = rclk_r;
    assign ev_o     = ev_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            phase   <= PH_IDLE;
            decided <= 1'b0;
            first   <= 1'b1;
            rclk_r  <= 1'b1;
            ev_r    <= '0;
        end else begin
            ev_r <= '0;
            if (arm_i) begin
                first   <= 1'b1;
                phase   <= PH_IDLE;
                decided <= 1'b0;
                rclk_r  <= 1'b1;
            end else if (!enable_i) begin
                phase  <= PH_IDLE;
                rclk_r <= 1'b1;
            end else begin
                if (cnt != '1) cnt <= cnt + 1'b1;
                if (!rclk_r && cnt >= one_w_i) rclk_r <= 1'b1;
                if (fall_i && guard_ok && phase != PH_LOW) begin
                    phase   <= PH_LOW;
                    cnt     <= '0;
                    rclk_r  <= 1'b0;
                    decided <= 1'b0;
                    first   <= 1'b0;
                end else if (phase == PH_LOW) begin
                    if (rise_i) begin
                        phase <= PH_HIGH;
                        if (!decided) ev_r <= '{valid: 1'b1, data: ~over};
                    end else if (!decided && over) begin
                        decided <= 1'b1;
                        ev_r    <= '{valid: 1'b1, data: 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pwmdec_zero_watch.sv
module pwmdec_zero_watch
    import pwmdec_pkg::*;
#(
    parameter int LIMIT = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clear_i,
    input  bit_ev_t ev_i,
    output logic    trip_o,
    output logic [$clog2(LIMIT+1)-1:0] run_o
);
    localparam int ZW = $clog2(LIMIT + 1);
    localparam logic [ZW-1:0] LAST = ZW'(LIMIT - 1);

    logic [ZW-1:0] run;

    assign trip_o = ev_i.valid & ~ev_i.data & (run == LAST);
    assign run_o  = run;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            run <= '0;
        end else if (ev_i.valid) begin
            if (ev_i.data || trip_o) run <= '0;
            else                     run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_bit_decoder.sv
module pwm_bit_decoder
    import pwmdec_pkg::*;
#(
    parameter int CLK_HZ        = 100_000_000,
    parameter int MIN_BPS       = 2400,
    parameter int LEARN_PERIODS = LEARN_PERIODS_DEF,
    parameter int ZERO_RUN      = ZERO_RUN_DEF,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_i,
    input  logic normal_start_i,
    input  logic por_i,
    output logic rclk_o,
    output logic data_o,
    output logic bit_valid_o,
    output logic ready_o
);
    localparam int MAX_CNT = 2 * (CLK_HZ / MIN_BPS);
    localparam int CW      = $clog2(MAX_CNT + 1);

    mode_e         mode_q;
    logic          fall, rise, done, tim_valid, trip;
    logic [CW-1:0] one_w, period_w;
    bit_ev_t       ev;
    logic          learn_clear, arm, ready_q, data_q;
    logic [$clog2(ZERO_RUN+1)-1:0] zrun;

    assign learn_clear = por_i | (normal_start_i & ~tim_valid) | trip;
    assign arm         = por_i | normal_start_i | trip;

    pwmdec_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(bus_i), .fall_o(fall), .rise_o(rise)
    );

    pwmdec_learner #(.CW(CW), .LEARN_PERIODS(LEARN_PERIODS)) u_learn (
        .clk(clk), .rst(rst), .clear_i(learn_clear),
        .enable_i(mode_q == MODE_LEARN), .fall_i(fall), .rise_i(rise),
        .done_o(done), .valid_o(tim_valid), .one_w_o(one_w), .period_o(period_w)
    );

    pwmdec_slicer #(.CW(CW)) u_slice (
        .clk(clk), .rst(rst), .enable_i((mode_q == MODE_RUN) | done),
        .arm_i(arm), .fall_i(fall), .rise_i(rise),
        .one_w_i(one_w), .period_i(period_w), .rclk_o(rclk_o), .ev_o(ev)
    );

    pwmdec_zero_watch #(.LIMIT(ZERO_RUN)) u_zero (
        .clk(clk), .rst(rst), .clear_i(arm), .ev_i(ev), .trip_o(trip), .run_o(zrun)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_OFF;
            ready_q <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            if (por_i)                               mode_q <= MODE_OFF;
            else if (normal_start_i)                 mode_q <= tim_valid ? MODE_RUN : MODE_LEARN;
            else if (mode_q == MODE_RUN && trip)     mode_q <= MODE_LEARN;
            else if (mode_q == MODE_LEARN && done)   mode_q <= MODE_RUN;

            if (por_i || normal_start_i || trip) ready_q <= 1'b0;
            else if (ev.valid)                   ready_q <= 1'b1;

            if (ev.valid) data_q <= ev.data;
        end
    end

    assign bit_valid_o = ev.valid;
    assign data_o      = ev.valid ? ev.data : data_q;
    assign ready_o     = ready_q;
endmodule

// File: rtl/pwm_bit_decoder_chk.sv
module pwm_bit_decoder_chk
    import pwmdec_pkg::*;
#(
    parameter int ZERO_RUN = ZERO_RUN_DEF
) (
    input logic  clk,
    input logic  rst,
    input logic  normal_start_i,
    input logic  por_i,
    input logic  rclk_o,
    input logic  data_o,
    input logic  bit_valid_o,
    input logic  ready_o,
    input mode_e mode_i,
    input logic  valid_i,
    input logic [$clog2(ZERO_RUN+1)-1:0] zrun_i
);
    p_por_idle_r1: assert property (@(posedge clk) disable iff (rst)
        por_i |=> (!ready_o && rclk_o && !bit_valid_o));

    p_silent_learning_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_LEARN) |-> !bit_valid_o);

    p_ready_after_one_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_valid_o && data_o && !por_i && !normal_start_i) |=> ready_o);

    p_strobe_drops_ready_r7: assert property (@(posedge clk) disable iff (rst)
        normal_start_i |=> !ready_o);

    p_ready_needs_timing_r8: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> valid_i);

    p_zero_run_bound_r9: assert property (@(posedge clk) disable iff (rst)
        zrun_i < ($clog2(ZERO_RUN+1))'(ZERO_RUN));

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        bit_valid_o |=> !bit_valid_o);
endmodule

bind pwm_bit_decoder pwm_bit_decoder_chk #(.ZERO_RUN(ZERO_RUN)) u_chk (
    .clk(clk), .rst(rst), .normal_start_i(normal_start_i), .por_i(por_i),
    .rclk_o(rclk_o), .data_o(data_o), .bit_valid_o(bit_valid_o), .ready_o(ready_o),
    .mode_i(mode_q), .valid_i(tim_valid), .zrun_i(zrun)
);

// File: tb/pwm_bit_decoder_tb.sv
module pwm_bit_decoder_tb;
    localparam int PER     = 400;
    localparam int ONE_LOW = 100;
    localparam int ZER_LOW = 250;

    typedef struct {
        logic  b;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus = 1'b1;
    logic nstart = 1'b0;
    logic por = 1'b0;
    logic rclk, data, bvalid, ready;

    int   vectors = 0;
    int   fails   = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    pwm_bit_decoder u_dut (
        .clk(clk), .rst(rst), .bus_i(bus), .normal_start_i(nstart), .por_i(por),
        .rclk_o(rclk), .data_o(data), .bit_valid_o(bvalid), .ready_o(ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int low, input int per);
        @(negedge clk) bus = 1'b0;
        repeat (low) @(negedge clk);
        bus = 1'b1;
        repeat (per - low - 1) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input string tag);
        q.push_back('{b: b, tag: tag});
        pulse(b ? ONE_LOW : ZER_LOW, PER);
    endtask

    task automatic strobe();
        @(negedge clk) nstart = 1'b1;
        @(negedge clk) nstart = 1'b0;
    endtask

    task automatic learn_clean();
        for (int i = 0; i < 33; i++) pulse(ONE_LOW, PER);
    endtask

    // monitor: pops expected bits as the design produces them
    always @(negedge clk) begin
        if (!rst && bvalid && !finished) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2/R11 unexpected bit", int'(data), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(data === e.b, e.tag, int'(data), int'(e.b));
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R1 reset ready", int'(ready), 0);
        chk(rclk == 1'b1, "R1 reset rclk", int'(rclk), 1);
        chk(bvalid == 1'b0, "R1 reset valid", int'(bvalid), 0);
        // bus activity before any strobe: nothing decoded (R1)
        for (int i = 0; i < 3; i++) pulse(ONE_LOW, PER);
        chk(ready == 1'b0, "R1 idle ready", int'(ready), 0);

        // R2: learning window after power-up
        strobe();
        learn_clean();
        chk(ready == 1'b0, "R2 ready during learning", int'(ready), 0);

        // R5, R4: first bit is the one after the window
        send_bit(1'b1, "R5 first decoded bit");
        chk(ready == 1'b1, "R7 ready after first bit", int'(ready), 1);
        send_bit(1'b0, "R4 zero");
        send_bit(1'b1, "R4 one");
        send_bit(1'b1, "R4 one");
        send_bit(1'b0, "R4 zero");

        // R6: recovered clock shape
        q.push_back('{b: 1'b1, tag: "R6 bit"});
        @(negedge clk) bus = 1'b0;
        repeat (50) @(negedge clk);
        chk(rclk == 1'b0, "R6 rclk low in low phase", int'(rclk), 0);
        repeat (50) @(negedge clk);
        bus = 1'b1;
        repeat (50) @(negedge clk);
        chk(rclk == 1'b1, "R6 rclk back high", int'(rclk), 1);
        repeat (PER - 151) @(negedge clk);

        // R10: glitch inside the high phase is ignored
        q.push_back('{b: 1'b1, tag: "R10 bit with glitch"});
        @(negedge clk) bus = 1'b0;
        repeat (ONE_LOW) @(negedge clk);
        bus = 1'b1;
        repeat (20) @(negedge clk);
        bus = 1'b0;
        repeat (10) @(negedge clk);
        bus = 1'b1;
        repeat (PER - ONE_LOW - 31) @(negedge clk);
        send_bit(1'b0, "R10 bit after glitch");
        chk(q.size() == 0, "R10 no extra bits", q.size(), 0);

        // R8: re-entry with stored timing decodes at once
        strobe();
        chk(ready == 1'b0, "R7 strobe drops ready", int'(ready), 0);
        send_bit(1'b0, "R8 immediate decode");
        chk(ready == 1'b1, "R8 ready after first bit", int'(ready), 1);

        // R9: ten zeros force re-learning
        send_bit(1'b1, "R9 one before run");
        for (int i = 0; i < 10; i++) send_bit(1'b0, "R9 zero run");
        chk(ready == 1'b0, "R9 ready dropped", int'(ready), 0);

        // R3: noise pulse in window corrupts learned width
        pulse(20, PER);
        for (int i = 0; i < 32; i++) pulse(ONE_LOW, PER);
        chk(ready == 1'b0, "R9 window silent", int'(ready), 0);
        for (int i = 0; i < 10; i++) begin
            q.push_back('{b: 1'b0, tag: "R3 ones read as zero"});
            pulse(ONE_LOW, PER);
        end
        chk(ready == 1'b0, "R3 corrupted width relearns", int'(ready), 0);
        learn_clean();
        send_bit(1'b1, "R9 clean after relearn");
        send_bit(1'b0, "R9 clean after relearn");
        chk(ready == 1'b1, "R9 ready after relearn", int'(ready), 1);

        // R1: power loss discards timing
        @(negedge clk) por = 1'b1;
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R1 por ready", int'(ready), 0);
        chk(rclk == 1'b1, "R1 por rclk", int'(rclk), 1);
        por = 1'b0;
        strobe();
        learn_clean();
        chk(ready == 1'b0, "R2 learning after por", int'(ready), 0);
        send_bit(1'b1, "R2 decode after por window");
        chk(ready == 1'b1, "R7 ready after por window", int'(ready), 1);

        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R11 all expected bits seen", q.size(), 0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule